// File: doc/BRIEF.md
# Serial Controller Status and Error Unit

This unit holds the status state of a serial controller: an enable bit that chooses between configuration mode (enable clear) and run mode (enable set), a master-select bit, and six error flags. These are transmit error, receive error, abort, transmit underflow, receive underflow and mode error. Software never writes a status bit directly. Each bit has its own set command bit and its own clear command bit in a write-only command word. This lets one write change some flags and leave the others alone, without a read-modify-write cycle.

The datapath reports error events on five pulse inputs. Each event sets its flag only while the matching error enable in the control word is on. Four interrupt request lines leave the unit: receive, transmit, error and frame end. Each is gated by its bit in a 4-bit mask. The error line is the OR of all six error flags. A simple register port gives access: a write strobe with address and data, and combinational read data. Control-word and mask writes are refused while the datapath reports busy.

Top module: `serial_status_unit`

## Requirements
- R1: After reset, the status, control and mask reads return 0, and all four interrupt lines, `run_mode` and `master_mode` are low.
- R2: A write to address 0 is a command word. Bit 0 clears enable, bit 1 sets enable, bit 2 clears master and bit 3 sets master. Reading address 0 shows enable at bit 0, master at bit 1, mode error at bit 7 and the `busy` input at bit 13. `run_mode` and `master_mode` follow the enable and master bits.
- R3: These command bits set an error flag: 5 receive underflow, 7 mode error, 12 transmit error, 13 receive error, 14 abort, 15 transmit underflow. These command bits clear one: 4 receive underflow, 6 mode error, 8 transmit error, 9 receive error, 10 abort, 11 transmit underflow. The flags read at status bits 8 (transmit error), 9 (receive error), 10 (abort), 11 (transmit underflow) and 12 (receive underflow).
- R4: The command value 0x0F50 clears all six error flags in one write and leaves enable and master unchanged.
- R5: A command word that asserts both the set bit and the clear bit of the same flag leaves that flag unchanged.
- R6: Address 1 is the control word, with error enables at bits 8 to 12, aligned with the status flags. `hw_err` bits 0 to 4 (transmit error, receive error, abort, transmit underflow, receive underflow) set their flag one cycle later only while the matching enable is set. Otherwise they have no effect.
- R7: A hardware error event in the same cycle as a command clearing that flag leaves the flag set.
- R8: Writes to address 1 (control word) and address 2 (interrupt mask) are ignored while `busy` is high.
- R9: Address 2 holds the interrupt mask in bits 3:0. `irq[0]` = `rx_req` AND mask bit 0, `irq[1]` = `tx_req` AND mask bit 1, `irq[3]` = `frame_req` AND mask bit 3.
- R10: `irq[2]` is high exactly when any error flag is set and mask bit 2 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 command/status, 1 control, 2 mask |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| busy | input | 1 | Datapath busy indication |
| hw_err | input | 5 | Hardware error event pulses |
| rx_req | input | 1 | Receive interrupt request from datapath |
| tx_req | input | 1 | Transmit interrupt request from datapath |
| frame_req | input | 1 | Frame-end interrupt request from datapath |
| run_mode | output | 1 | Enable bit (run mode when high) |
| master_mode | output | 1 | Master-select bit |
| irq | output | 4 | Masked interrupt lines: rx, tx, error, frame end |

## Verification
A software clear and a hardware error event can land on the same flag in the same cycle. The bench provokes this by driving an `hw_err` pulse during the clock edge that takes the all-errors clear command. It then judges the result by reading the status word: the hit flag must read set, and every other error flag must read cleared. The second collision is a set and a clear of one flag in a single command word. The bench checks it with the flag both low and high beforehand and expects no change.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  localparam int NFLAG = 8;
  localparam int F_EN  = 0;
  localparam int F_MS  = 1;
  localparam int F_TE  = 2;
  localparam int F_RE  = 3;
  localparam int F_AE  = 4;
  localparam int F_TUE = 5;
  localparam int F_RUE = 6;
  localparam int F_ME  = 7;
  localparam int HW_FIRST = F_TE;
  localparam int HW_LAST  = F_RUE;
  localparam int BUSY_POS = 13;

  function automatic int set_pos(input int f);
    case (f)
      F_EN:    set_pos = 1;
      F_MS:    set_pos = 3;
      F_TE:    set_pos = 12;
      F_RE:    set_pos = 13;
      F_AE:    set_pos = 14;
      F_TUE:   set_pos = 15;
      F_RUE:   set_pos = 5;
      default: set_pos = 7;
    endcase
  endfunction

  function automatic int clr_pos(input int f);
    case (f)
      F_EN:    clr_pos = 0;
      F_MS:    clr_pos = 2;
      F_TE:    clr_pos = 8;
      F_RE:    clr_pos = 9;
      F_AE:    clr_pos = 10;
      F_TUE:   clr_pos = 11;
      F_RUE:   clr_pos = 4;
      default: clr_pos = 6;
    endcase
  endfunction

  function automatic int stat_pos(input int f);
    case (f)
      F_EN:    stat_pos = 0;
      F_MS:    stat_pos = 1;
      F_TE:    stat_pos = 8;
      F_RE:    stat_pos = 9;
      F_AE:    stat_pos = 10;
      F_TUE:   stat_pos = 11;
      F_RUE:   stat_pos = 12;
      default: stat_pos = 7;
    endcase
  endfunction
endpackage

// File: rtl/ssu_flag_cell.sv
module ssu_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic hw_set,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      q <= 1'b0;
    else if (hw_set)
      q <= 1'b1;
    else if (sw_set && !sw_clr)
      q <= 1'b1;
    else if (sw_clr && !sw_set)
      q <= 1'b0;
  end
endmodule

// File: rtl/ssu_cfg_regs.sv
module ssu_cfg_regs #(
  parameter int ERR_N = 5,
  parameter int IRQ_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             ctrl_we,
  input  logic             mask_we,
  input  logic [ERR_N-1:0] ctrl_wdata,
  input  logic [IRQ_N-1:0] mask_wdata,
  output logic [ERR_N-1:0] err_en,
  output logic [IRQ_N-1:0] irq_mask
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_en   <= '0;
      irq_mask <= '0;
    end else if (!busy) begin
      if (ctrl_we) err_en   <= ctrl_wdata;
      if (mask_we) irq_mask <= mask_wdata;
    end
  end
endmodule

// File: rtl/ssu_irq_gate.sv
module ssu_irq_gate #(
  parameter int IRQ_N = 4
) (
  input  logic [IRQ_N-1:0] req,
  input  logic [IRQ_N-1:0] mask,
  output logic [IRQ_N-1:0] irq
);
  for (genvar k = 0; k < IRQ_N; k++) begin : g_line
    assign irq[k] = req[k] & mask[k];
  end
endmodule

// File: rtl/serial_status_unit.sv
module serial_status_unit #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              busy,
  input  logic [4:0]        hw_err,
  input  logic              rx_req,
  input  logic              tx_req,
  input  logic              frame_req,
  output logic              run_mode,
  output logic              master_mode,
  output logic [3:0]        irq
);
  import ssu_pkg::*;

  localparam int ERR_N   = HW_LAST - HW_FIRST + 1;
  localparam int IRQ_N   = 4;
  localparam int ERR_LSB = 8;
  localparam int IRQ_ERR = 2;

  logic             cmd_we, ctrl_we, mask_we;
  logic [NFLAG-1:0] flags;
  logic [ERR_N-1:0] err_en;
  logic [IRQ_N-1:0] irq_mask;
  logic [IRQ_N-1:0] irq_req;
  logic             err_any;

  assign cmd_we  = reg_we && (reg_addr == ADDR_W'(0));
  assign ctrl_we = reg_we && (reg_addr == ADDR_W'(1));
  assign mask_we = reg_we && (reg_addr == ADDR_W'(2));

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    logic hw_hit;
    if (i >= HW_FIRST && i <= HW_LAST) begin : g_hw
      assign hw_hit = hw_err[i-HW_FIRST] & err_en[i-HW_FIRST];
    end else begin : g_sw
      assign hw_hit = 1'b0;
    end
    ssu_flag_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .sw_set (cmd_we & reg_wdata[set_pos(i)]),
      .sw_clr (cmd_we & reg_wdata[clr_pos(i)]),
      .hw_set (hw_hit),
      .q      (flags[i])
    );
  end

  ssu_cfg_regs #(.ERR_N(ERR_N), .IRQ_N(IRQ_N)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .ctrl_we    (ctrl_we),
    .mask_we    (mask_we),
    .ctrl_wdata (reg_wdata[ERR_LSB +: ERR_N]),
    .mask_wdata (reg_wdata[IRQ_N-1:0]),
    .err_en     (err_en),
    .irq_mask   (irq_mask)
  );

  assign err_any = |flags[NFLAG-1:HW_FIRST];
  assign irq_req = {frame_req, err_any, tx_req, rx_req};

  ssu_irq_gate #(.IRQ_N(IRQ_N)) u_irq (
    .req  (irq_req),
    .mask (irq_mask),
    .irq  (irq)
  );

  assign run_mode    = flags[F_EN];
  assign master_mode = flags[F_MS];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(0): begin
        for (int i = 0; i < NFLAG; i++) reg_rdata[stat_pos(i)] = flags[i];
        reg_rdata[BUSY_POS] = busy;
      end
      ADDR_W'(1): reg_rdata[ERR_LSB +: ERR_N] = err_en;
      ADDR_W'(2): reg_rdata[IRQ_N-1:0] = irq_mask;
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ssu_chk.sv
module ssu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [1:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic        busy,
  input logic [4:0]  hw_err,
  input logic [7:0]  flags,
  input logic [4:0]  err_en,
  input logic [3:0]  irq_mask,
  input logic [3:0]  irq
);
  logic cmd_wr;
  assign cmd_wr = reg_we && reg_addr == 2'd0;

  // R5
  both_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && reg_wdata[0] && reg_wdata[1] |=> $stable(flags[0]));

  // R6
  hw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_err[0] && err_en[0] |=> flags[2]);

  // R6
  hw_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_en[0] && !cmd_wr |=> $stable(flags[2]));

  // R4
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && reg_wdata == 16'h0F50 && hw_err == 5'd0 |=> flags[7:2] == 6'd0);

  // R8
  busy_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_we && reg_addr != 2'd0 |=> $stable(err_en) && $stable(irq_mask));

  // R10
  irq_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_mask[2] |-> !irq[2]);
endmodule

bind serial_status_unit ssu_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .busy      (busy),
  .hw_err    (hw_err),
  .flags     (flags),
  .err_en    (err_en),
  .irq_mask  (irq_mask),
  .irq       (irq)
);

// File: tb/test_serial_status_unit.sv
module test_serial_status_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        busy = 1'b0;
  logic [4:0]  hw_err = '0;
  logic        rx_req = 1'b0, tx_req = 1'b0, frame_req = 1'b0;
  logic        run_mode, master_mode;
  logic [3:0]  irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_status_unit i_serial_status_unit (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .hw_err(hw_err), .rx_req(rx_req), .tx_req(tx_req),
    .frame_req(frame_req), .run_mode(run_mode),
    .master_mode(master_mode), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // write takes effect at the posedge; returns at the following negedge
  task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic [4:0] ev);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d; hw_err = ev;
    @(negedge clk);
    reg_we = 1'b0; hw_err = '0;
  endtask

  task automatic event_only(input logic [4:0] ev);
    @(negedge clk);
    hw_err = ev;
    @(negedge clk);
    hw_err = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(2'd0, d); chk("R1 status", d, 16'h0000);
    rd(2'd1, d); chk("R1 control", d, 16'h0000);
    rd(2'd2, d); chk("R1 mask", d, 16'h0000);
    chk("R1 outputs", {12'd0, irq}, {12'd0, 4'h0});
    chk("R1 modes", {14'd0, run_mode, master_mode}, 16'd0);
  endtask

  task automatic t_modes();
    logic [15:0] d;
    wr(2'd0, 16'h0002, 5'd0);
    rd(2'd0, d); chk("R2 set enable", d, 16'h0001);
    chk("R2 run_mode", {15'd0, run_mode}, 16'd1);
    wr(2'd0, 16'h0008, 5'd0);
    rd(2'd0, d); chk("R2 set master", d, 16'h0003);
    chk("R2 master_mode", {15'd0, master_mode}, 16'd1);
    wr(2'd0, 16'h0001, 5'd0);
    rd(2'd0, d); chk("R2 clear enable", d, 16'h0002);
    busy = 1'b1;
    rd(2'd0, d); chk("R2 busy bit", d, 16'h2002);
    busy = 1'b0;
    wr(2'd0, 16'h0004, 5'd0);
    rd(2'd0, d); chk("R2 clear master", d, 16'h0000);
  endtask

  task automatic t_sw_errors();
    logic [15:0] d;
    wr(2'd0, 16'h1000, 5'd0); rd(2'd0, d); chk("R3 set tx err", d, 16'h0100);
    wr(2'd0, 16'h2000, 5'd0); rd(2'd0, d); chk("R3 set rx err", d, 16'h0300);
    wr(2'd0, 16'h4000, 5'd0); rd(2'd0, d); chk("R3 set abort", d, 16'h0700);
    wr(2'd0, 16'h8000, 5'd0); rd(2'd0, d); chk("R3 set tx udf", d, 16'h0F00);
    wr(2'd0, 16'h0020, 5'd0); rd(2'd0, d); chk("R3 set rx udf", d, 16'h1F00);
    wr(2'd0, 16'h0080, 5'd0); rd(2'd0, d); chk("R3 set mode err", d, 16'h1F80);
    wr(2'd0, 16'h0200, 5'd0); rd(2'd0, d); chk("R3 clear rx err", d, 16'h1D80);
    wr(2'd0, 16'h0040, 5'd0); rd(2'd0, d); chk("R3 clear mode err", d, 16'h1D00);
  endtask

  task automatic t_clear_all();
    logic [15:0] d;
    wr(2'd0, 16'hF0AA, 5'd0);
    rd(2'd0, d); chk("R4 all set", d, 16'h1F83);
    wr(2'd0, 16'h0F50, 5'd0);
    rd(2'd0, d); chk("R4 clear all", d, 16'h0003);
    wr(2'd0, 16'h0005, 5'd0);
    rd(2'd0, d); chk("R4 cleanup", d, 16'h0000);
  endtask

  task automatic t_both();
    logic [15:0] d;
    wr(2'd0, 16'h0003, 5'd0);
    rd(2'd0, d); chk("R5 both on low enable", d, 16'h0000);
    wr(2'd0, 16'h1100, 5'd0);
    rd(2'd0, d); chk("R5 both on low tx err", d, 16'h0000);
    wr(2'd0, 16'h1000, 5'd0);
    wr(2'd0, 16'h1100, 5'd0);
    rd(2'd0, d); chk("R5 both on high tx err", d, 16'h0100);
    wr(2'd0, 16'h0F50, 5'd0);
  endtask

  task automatic t_hw_gate();
    logic [15:0] d;
    event_only(5'b11111);
    rd(2'd0, d); chk("R6 disabled events ignored", d, 16'h0000);
    wr(2'd1, 16'h0500, 5'd0);
    rd(2'd1, d); chk("R6 control readback", d, 16'h0500);
    event_only(5'b11111);
    rd(2'd0, d); chk("R6 enabled events only", d, 16'h0500);
    wr(2'd0, 16'h0F50, 5'd0);
  endtask

  task automatic t_priority();
    logic [15:0] d;
    wr(2'd1, 16'h1F00, 5'd0);
    wr(2'd0, 16'hF020, 5'd0);
    wr(2'd0, 16'h0F50, 5'b01000);
    rd(2'd0, d); chk("R7 event beats clear", d, 16'h0800);
    wr(2'd0, 16'h0F50, 5'd0);
  endtask

  task automatic t_busy();
    logic [15:0] d;
    busy = 1'b1;
    wr(2'd1, 16'h0000, 5'd0);
    wr(2'd2, 16'h000F, 5'd0);
    busy = 1'b0;
    rd(2'd1, d); chk("R8 control held", d, 16'h1F00);
    rd(2'd2, d); chk("R8 mask held", d, 16'h0000);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    rx_req = 1; tx_req = 1; frame_req = 1;
    #1; chk("R9 all masked", {12'd0, irq}, 16'h0000);
    wr(2'd2, 16'h0009, 5'd0);
    rd(2'd2, d); chk("R9 mask readback", d, 16'h0009);
    chk("R9 rx and frame", {12'd0, irq}, 16'h0009);
    rx_req = 0; #1;
    chk("R9 rx dropped", {12'd0, irq}, 16'h0008);
    wr(2'd2, 16'h0002, 5'd0); #1;
    chk("R9 tx only", {12'd0, irq}, 16'h0002);
    rx_req = 0; tx_req = 0; frame_req = 0;
    wr(2'd2, 16'h0004, 5'd0); #1;
    chk("R10 no errors", {12'd0, irq}, 16'h0000);
    wr(2'd0, 16'h0080, 5'd0); #1;
    chk("R10 mode err raises", {12'd0, irq}, 16'h0004);
    wr(2'd2, 16'h0000, 5'd0); #1;
    chk("R10 masked", {12'd0, irq}, 16'h0000);
    wr(2'd2, 16'h0004, 5'd0);
    wr(2'd0, 16'h0F50, 5'd0); #1;
    chk("R10 cleared", {12'd0, irq}, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_sw_errors();
    t_clear_all();
    t_both();
    t_hw_gate();
    t_priority();
    t_busy();
    t_irq();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule